// File: doc/BRIEF.md
# Serial Memory Bus Slave with Random Read

This block is the bus-facing half of a 512-byte serial memory. It oversamples the two-wire clock and data lines with the system clock, finds start, repeated-start and stop conditions, and decodes an addressing byte. The addressing byte carries a fixed device type, two strap bits compared against pins, a half-select bit and a direction bit. A write transfer loads a word address into an internal counter and then stores data bytes. A read transfer returns bytes from the counter's location. A random read is a write transfer that carries only the word address, then a repeated start and an addressing byte with the direction bit set.

The data line is open-drain. The block only ever pulls it low, through `sda_oe`. The storage is an internal 512x8 register array. The half-select bit is bit 8 of the memory address and the counter supplies bits 7..0, so the counter wraps inside one 256-byte half.

The control path is a state machine with these states:
- `ST_IDLE`: waits for a start.
- `ST_DEV`: receives the addressing byte.
- `ST_DEV_ACK`: acknowledges the addressing byte.
- `ST_WADDR` and `ST_WADDR_ACK`: receive and acknowledge the word address.
- `ST_WDATA` and `ST_WDATA_ACK`: receive, store and acknowledge data.
- `ST_RDATA`: shifts a byte out.
- `ST_RACK`: samples the master's acknowledge.

Its transitions are:
- A start goes from any state to `ST_DEV`, and a stop goes from any state to `ST_IDLE`.
- At the end of `ST_DEV`, a matching byte goes to `ST_DEV_ACK` and a mismatch goes to `ST_IDLE`.
- `ST_DEV_ACK` goes to `ST_RDATA` when the direction bit is 1, and to `ST_WADDR` when it is 0.
- `ST_WADDR` goes to `ST_WADDR_ACK`, and `ST_WADDR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes to `ST_RDATA` on a master ACK and to `ST_IDLE` on a NACK.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and every memory byte reads as 0x00.
- R2: A start (SDA falling while SCL is high) aborts any transfer in progress and begins a new addressing byte. A stop (SDA rising while SCL is high) returns the block to idle. An abandoned partial data byte is not stored. After a stop, clocked bits without a start are never acknowledged.
- R3: The addressing byte is received MSB first. Bits 7..4 must be 1010, bits 3..2 must equal `strap_i[1:0]`, bit 1 is the half-select and bit 0 is the direction (0 = write, 1 = read). A matching byte is acknowledged by holding `sda_oe` high through the ninth SCL high phase. On a mismatch, `sda_oe` stays 0 and every following byte is ignored until the next start, and memory is unchanged.
- R4: In a write transfer, the next byte is the word address, MSB first. It is acknowledged and loads the counter. Each following byte is acknowledged, stored at {half-select, counter}, and then the counter increments. A read with no word address starts at the counter as left by the last transfer.
- R5: After a word address, a repeated start and a matching addressing byte with direction 1 are acknowledged. The byte at {half-select, counter} is then driven D7 first, with `sda_oe` = NOT data bit during each SCL high phase.
- R6: If the master leaves SDA high on the ninth clock after a read byte, the block releases SDA and drives nothing more until the next start.
- R7: If the master pulls SDA low on the ninth clock after a read byte, the block sends the byte at the incremented address.
- R8: The counter wraps from 0xFF to 0x00 without changing the half-select bit.
- R9: Half-select 0 and half-select 1 with the same word address reach two distinct bytes.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| strap_i | input | 2 | Strap pins compared with addressing-byte bits 3..2 |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |

## Verification
Two events meet at the falling SCL edge that ends a transmitted byte. The counter advances on that edge, and the registered read of the array must refresh before the next byte is loaded at the following falling edge. The same edge also carries the release of SDA for the master's acknowledge. Sequential reads with master ACK are used to provoke this, including a read that crosses the 0xFF-to-0x00 wrap within a half. A behavioural model of the memory and counter in the bench predicts the level of `sda_oe` for every SCL-high clock. Each such clock is compared, so a stale byte, a late release or a wrong half shows up at the bit where it occurs.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    // Fixed geometry: one half-select bit on top of an 8-bit word counter.
    localparam int WORD_W = 8;
    localparam int ADDR_W = WORD_W + 1;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_t;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
    parameter int SYNC_STAGES = 2   // must be 2 or more
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    // Idle bus is high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_sync[SYNC_STAGES-1];
            sda_q    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sync[SYNC_STAGES-1];
    assign sda_s     = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array
    import i2c_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read that follows the address every cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_mem_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap_i,
    input  logic [7:0]        rdata,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output slv_state_t        state_o
);

    slv_state_t        state;
    slv_state_t        nstate;
    logic [7:0]        shreg;
    logic [3:0]        bitcnt;
    logic              byte_done;
    logic              rw_q;
    logic              bs_q;
    logic [WORD_W-1:0] word_q;
    logic [7:0]        tx_q;
    logic              mack_q;
    logic              oe_q;
    logic              dev_match;
    logic              byte_end;

    assign dev_match = (shreg[7:4] == DEV_CODE) && (shreg[3:2] == strap_i);
    assign byte_end  = scl_fall && byte_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        if (start_det) begin
            nstate = ST_DEV;
        end else if (stop_det) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_DEV:       if (byte_end) nstate = dev_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) nstate = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_end) nstate = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) nstate = ST_WDATA;
                ST_WDATA:     if (byte_end) nstate = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nstate = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt == 4'd8) nstate = ST_RACK;
                ST_RACK:      if (scl_fall) nstate = mack_q ? ST_RDATA : ST_IDLE;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= 8'h00;
            bitcnt    <= 4'd0;
            byte_done <= 1'b0;
            rw_q      <= 1'b0;
            bs_q      <= 1'b0;
            word_q    <= '0;
            tx_q      <= 8'h00;
            mack_q    <= 1'b0;
            oe_q      <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt    <= 4'd0;
            byte_done <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            byte_done <= 1'b1;
                        end
                    end else if (byte_end) begin
                        byte_done <= 1'b0;
                        bitcnt    <= 4'd0;
                        if (state == ST_DEV) begin
                            if (dev_match) begin
                                rw_q <= shreg[0];
                                bs_q <= shreg[1];
                                oe_q <= 1'b1;
                            end
                        end else if (state == ST_WADDR) begin
                            word_q <= shreg;
                            oe_q   <= 1'b1;
                        end else begin
                            word_q <= word_q + 1'b1;
                            oe_q   <= 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= 4'd0;
                        if (rw_q) begin
                            oe_q <= ~rdata[7];
                            tx_q <= {rdata[6:0], 1'b0};
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        oe_q   <= 1'b0;
                        bitcnt <= 4'd0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            oe_q   <= 1'b0;
                            word_q <= word_q + 1'b1;
                        end else begin
                            oe_q <= ~tx_q[7];
                            tx_q <= {tx_q[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= 4'd0;
                        if (mack_q) begin
                            oe_q <= ~rdata[7];
                            tx_q <= {rdata[6:0], 1'b0};
                        end
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign mem_we    = (state == ST_WDATA) && byte_end && !start_det && !stop_det;
    assign mem_waddr = {bs_q, word_q};
    assign mem_wdata = shreg;
    assign mem_raddr = {bs_q, word_q};
    assign sda_oe    = oe_q;
    assign state_o   = state;

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_oe
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [ADDR_W-1:0] mem_raddr;
    logic [7:0]        rdata;
    slv_state_t        fsm_state;

    i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_fsm #(.DEV_CODE(DEV_CODE)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (strap_i),
        .rdata     (rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .state_o   (fsm_state)
    );

    i2c_mem_array mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (rdata)
    );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
    import i2c_mem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       mem_we,
    input slv_state_t state
);

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s) else $error("oe changed with SCL high"); // R10

    AST_START_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV)) else $error("start not taken"); // R2

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE)) else $error("stop not taken"); // R2

    AST_NO_START_STOP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det})) else $error("start and stop together"); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_DEV) |-> !sda_oe) else $error("drive while idle"); // R3

    AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (state == ST_WDATA_ACK && sda_oe)) else $error("write outside data phase"); // R4

endmodule

bind i2c_mem_slave i2c_mem_slave_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .state     (fsm_state)
);

// File: tb/i2c_mem_slave_tb.sv
`timescale 1ns/1ps
module i2c_mem_slave_tb_top;

    localparam int HALF = 8;
    localparam logic [1:0] STRAP = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [1:0] strap = STRAP;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;
    bit    exp_valid = 0;
    bit    exp_oe = 0;
    string cur_req = "R1";

    // Behavioural model: memory image and word counter
    logic [7:0] ref_mem [512];
    int         ref_word = 0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_mem_slave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .strap_i (strap),
        .sda_oe  (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Every clock of an SCL-high phase is compared against the model.
    always @(negedge clk) begin
        if (exp_valid) chk(sda_oe === exp_oe, cur_req, "sda_oe per clock", int'(sda_oe), int'(exp_oe));
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_cycle(input bit m, input bit exp, input string req, output bit seen);
        step(2);
        m_sda = m;
        step(HALF);
        m_scl = 1'b1;
        step(2);
        cur_req = req;
        exp_oe = exp;
        exp_valid = 1'b1;
        step(HALF - 4);
        seen = sda_line;
        exp_valid = 1'b0;
        step(2);
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        step(HALF);
        m_scl = 1'b1;
        step(HALF);
        m_sda = 1'b0;
        step(HALF);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        step(2);
        m_sda = 1'b0;
        step(HALF);
        m_scl = 1'b1;
        step(HALF);
        m_sda = 1'b1;
        step(HALF);
    endtask

    task automatic write_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, req, s);
        bit_cycle(1'b1, exp_ack, req, s);
        chk(s == !exp_ack, req, "ack level", int'(s), int'(!exp_ack));
    endtask

    task automatic read_byte(input bit mack, input logic [7:0] expd, input string req);
        bit s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, ~expd[i], req, s);
            got[i] = s;
        end
        bit_cycle(~mack, 1'b0, req, s);
        chk(got == expd, req, "read byte", int'(got), int'(expd));
    endtask

    function automatic logic [7:0] dev_byte(input logic [1:0] a, input bit bs, input bit rd);
        return {4'b1010, a, bs, rd};
    endfunction

    task automatic do_write(input bit bs, input logic [7:0] word, input logic [7:0] data,
                            input string req);
        bus_start();
        write_byte(dev_byte(STRAP, bs, 1'b0), 1'b1, req);
        write_byte(word, 1'b1, req);
        write_byte(data, 1'b1, req);
        bus_stop();
        ref_mem[{bs, word}] = data;
        ref_word = (int'(word) + 1) % 256;
    endtask

    task automatic do_read(input bit bs, input logic [7:0] word, input int n, input string req);
        bus_start();
        write_byte(dev_byte(STRAP, bs, 1'b0), 1'b1, req);
        write_byte(word, 1'b1, req);
        bus_start();
        write_byte(dev_byte(STRAP, bs, 1'b1), 1'b1, req);
        for (int k = 0; k < n; k++) begin
            read_byte(k != n - 1, ref_mem[{bs, 8'((int'(word) + k) % 256)}], req);
        end
        bus_stop();
        ref_word = (int'(word) + n) % 256;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        bit s;
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
        step(5);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1", "oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        step(5);
        chk(sda_oe == 1'b0, "R1", "oe after reset", int'(sda_oe), 0);
        do_read(1'b0, 8'h00, 1, "R1");
        do_read(1'b1, 8'h80, 1, "R1");

        // R5 and R9: same word in both halves
        do_write(1'b0, 8'h10, 8'h3C, "R4");
        do_write(1'b1, 8'h10, 8'hA5, "R9");
        do_read(1'b0, 8'h10, 1, "R5");
        do_read(1'b1, 8'h10, 1, "R9");

        // R4: read with no word address continues from the counter
        do_write(1'b0, 8'h31, 8'h62, "R4");
        do_write(1'b0, 8'h30, 8'h61, "R4");
        bus_start();
        write_byte(dev_byte(STRAP, 1'b0, 1'b1), 1'b1, "R4");
        read_byte(1'b0, ref_mem[{1'b0, 8'(ref_word)}], "R4");
        bus_stop();

        // R7: sequential read with master ACK
        do_write(1'b1, 8'h20, 8'h11, "R7");
        do_write(1'b1, 8'h21, 8'hC2, "R7");
        do_write(1'b1, 8'h22, 8'h5E, "R7");
        do_read(1'b1, 8'h20, 3, "R7");

        // R8: wrap inside the half
        do_write(1'b1, 8'hFF, 8'h77, "R8");
        do_write(1'b1, 8'h00, 8'h88, "R8");
        do_read(1'b1, 8'hFF, 2, "R8");
        do_read(1'b0, 8'h00, 1, "R8");

        // R3: strap mismatch is ignored, memory unchanged
        bus_start();
        write_byte(dev_byte(2'b01, 1'b0, 1'b0), 1'b0, "R3");
        write_byte(8'h10, 1'b0, "R3");
        write_byte(8'hEE, 1'b0, "R3");
        bus_stop();
        do_read(1'b0, 8'h10, 1, "R3");
        // R3: wrong device type code
        bus_start();
        write_byte({4'b1011, STRAP, 1'b0, 1'b0}, 1'b0, "R3");
        bus_stop();

        // R6: NACK ends the read; later clocks see no drive
        ref_mem[{1'b0, 8'h11}] = ref_mem[{1'b0, 8'h11}];
        do_write(1'b0, 8'h11, 8'h00, "R6");
        bus_start();
        write_byte(dev_byte(STRAP, 1'b0, 1'b0), 1'b1, "R6");
        write_byte(8'h11, 1'b1, "R6");
        bus_start();
        write_byte(dev_byte(STRAP, 1'b0, 1'b1), 1'b1, "R6");
        read_byte(1'b0, 8'h00, "R6");
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, 1'b0, "R6", s);
        chk(s == 1'b1, "R6", "line after nack", int'(s), 1);
        bus_stop();

        // R2: start in the middle of a data byte aborts it
        do_write(1'b0, 8'h40, 8'h5A, "R2");
        bus_start();
        write_byte(dev_byte(STRAP, 1'b0, 1'b0), 1'b1, "R2");
        write_byte(8'h40, 1'b1, "R2");
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, 1'b0, "R2", s);
        bus_start();
        write_byte(dev_byte(STRAP, 1'b0, 1'b1), 1'b1, "R2");
        read_byte(1'b0, 8'h5A, "R2");
        bus_stop();
        // R2: after a stop, bits without a start get no ack
        for (int i = 7; i >= 0; i--) bit_cycle(dev_byte(STRAP, 1'b0, 1'b0) >> i, 1'b0, "R2", s);
        bit_cycle(1'b1, 1'b0, "R2", s);
        chk(s == 1'b1, "R2", "no ack without start", int'(s), 1);
        bus_stop();
        do_read(1'b0, 8'h40, 1, "R2");

        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

endmodule